// File: doc/BRIEF.md
# Four-Channel Down-Counter Bank with Watchdog Selection

The block holds four independent 64-bit down-counters behind a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Each channel has three registers: a control word and the two 32-bit halves of a 64-bit start value. The control word holds an enable bit, a read-only busy flag, a two-bit mode code and an 8-bit clock divider. A channel counts down once every divider-value clocks. A divider below two is treated as two.

A channel starts on a rising edge of its enable bit. At that edge it copies the start value into its live count and raises its busy flag. After it reaches zero it stops, and the busy flag drops. Enable stays set until software clears it. To restart a running channel, which is also how a watchdog is kicked, software clears enable, writes a new start value and sets enable again. A start value of zero expires one clock after enabling.

A global select register marks any channel as a watchdog. When a marked channel expires, a sticky `sys_rst_req` output rises and stays high until the next global reset. When an unmarked channel expires, it sets its own sticky flag on `cnt_expired` instead.

Top module: `cwb_timer_bank`

## Requirements
- R1: After reset, `sys_rst_req` and `cnt_expired` are 0, and every register reads 0.
- R2: Channel n has its control word at byte address 0x10·n, its start-value low half at 0x10·n+4 and its high half at 0x10·n+8. The select register is at 0x40, with bit n for channel n and the upper bits reading 0. Any other address, including one that is not word aligned, reads 0.
- R3: The control word reads back as: enable at bit 0, busy at bit 1 (writes to this bit are ignored), mode at bits 3:2, divider at bits 15:8, and all other bits 0. The start-value halves read back the last value written.
- R4: Take an enabling write at clock edge E0, start value N > 0 and divider P ≥ 2. The channel's expiry becomes visible right after edge E0+N·P+1 and not earlier. Busy reads 1 while the countdown runs.
- R5: Divider values 0 and 1 behave like 2.
- R6: A start value of 0 expires right after the first edge that follows the enabling write.
- R7: On expiry, busy clears and enable stays 1. Writing enable=1 again while enable is already 1 does not restart the channel. Mode code 00 is one-shot, and the other codes behave the same way.
- R8: An unmarked channel sets `cnt_expired[n]` on expiry. The flag holds until the next rising edge of that channel's enable, which clears it.
- R9: A marked channel sets `sys_rst_req` on expiry and leaves `cnt_expired[n]` at 0. `sys_rst_req` stays 1 until global reset.
- R10: While busy is 1, writes to the mode and divider fields are ignored. The enable bit is still written.
- R11: Start-value writes made while busy are stored and read back, but they do not change the running countdown.
- R12: Clearing enable stops the countdown at once, with no expiry. A later enable rising edge restarts the channel from the current start value.
- R13: The channels count independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cnt_expired | output | 4 | Sticky per-channel expiry flags for unmarked channels |
| sys_rst_req | output | 1 | Sticky reset request from a marked channel |

## Verification
The hardest case to reach is a channel whose state changes between two register writes of one sequence. In the disable-reload-enable kick, and in the write-lock case, the disable write lands while busy is still 1. That write must therefore be refused its divider field, while the identical write issued a cycle later is accepted. The bench reaches this with back-to-back writes whose edges it counts exactly. It also stops a channel two divider periods before zero and then runs many further cycles to show that no late expiry appears. The zero-start and edge-exact expiry checks sample one cycle before and one cycle after the predicted edge.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  // control word field positions
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_BUSY_BIT = 1;
  localparam int CTL_MODE_LSB = 2;
  localparam int CTL_DIV_LSB  = 8;
  localparam int MIN_DIV      = 2;

  // register offsets inside one channel window
  localparam int OFS_CTRL = 0;
  localparam int OFS_LO   = 4;
  localparam int OFS_HI   = 8;

  typedef enum logic [1:0] {
    MODE_ONE_SHOT = 2'b00,
    MODE_RSVD_1   = 2'b01,
    MODE_RSVD_2   = 2'b10,
    MODE_RSVD_3   = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/cwb_rst_sync.sv
module cwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cwb_counter.sv
module cwb_counter
  import cwb_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  input  logic             wd_sel,
  output logic [BUS_W-1:0] ctrl_rd,
  output logic [BUS_W-1:0] lo_rd,
  output logic [BUS_W-1:0] hi_rd,
  output logic             busy,
  output logic             expire_evt,
  output logic             expired
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

  logic             en_q, en_d;
  logic             busy_q, busy_d;
  logic             exp_q, exp_d;
  cnt_mode_e        mode_q, mode_d;
  logic [DIV_W-1:0] div_q, div_d, div_eff;
  logic [DIV_W-1:0] tick_q, tick_d;
  logic [CNT_W-1:0] start_q, start_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_rise;

  assign div_eff = (div_q < DIV_FLOOR) ? DIV_FLOOR : div_q;
  assign en_rise = wr_ctrl && wdata[CTL_EN_BIT] && !en_q;

  always_comb begin
    en_d       = en_q;
    busy_d     = busy_q;
    exp_d      = exp_q;
    mode_d     = mode_q;
    div_d      = div_q;
    tick_d     = tick_q;
    start_d    = start_q;
    cnt_d      = cnt_q;
    expire_evt = 1'b0;

    if (wr_lo) start_d[BUS_W-1:0]     = wdata;
    if (wr_hi) start_d[CNT_W-1:BUS_W] = wdata;

    if (wr_ctrl) begin
      en_d = wdata[CTL_EN_BIT];
      if (!busy_q) begin
        mode_d = cnt_mode_e'(wdata[CTL_MODE_LSB +: 2]);
        div_d  = wdata[CTL_DIV_LSB +: DIV_W];
      end
    end

    if (en_rise) begin
      cnt_d  = start_q;
      tick_d = '0;
      busy_d = 1'b1;
      exp_d  = 1'b0;
    end else if (wr_ctrl && !wdata[CTL_EN_BIT]) begin
      busy_d = 1'b0;
      tick_d = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        // every mode code currently runs as one-shot
        busy_d     = 1'b0;
        expire_evt = 1'b1;
        if (!wd_sel) exp_d = 1'b1;
      end else if (tick_q == div_eff - DIV_W'(1)) begin
        tick_d = '0;
        cnt_d  = cnt_q - CNT_W'(1);
      end else begin
        tick_d = tick_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      exp_q   <= 1'b0;
      mode_q  <= MODE_ONE_SHOT;
      div_q   <= '0;
      tick_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      en_q    <= en_d;
      busy_q  <= busy_d;
      exp_q   <= exp_d;
      mode_q  <= mode_d;
      div_q   <= div_d;
      tick_q  <= tick_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    ctrl_rd                           = '0;
    ctrl_rd[CTL_EN_BIT]               = en_q;
    ctrl_rd[CTL_BUSY_BIT]             = busy_q;
    ctrl_rd[CTL_MODE_LSB +: 2]        = mode_q;
    ctrl_rd[CTL_DIV_LSB +: DIV_W]     = div_q;
  end

  assign lo_rd   = start_q[BUS_W-1:0];
  assign hi_rd   = start_q[CNT_W-1:BUS_W];
  assign busy    = busy_q;
  assign expired = exp_q;
endmodule

// File: rtl/cwb_timer_bank.sv
module cwb_timer_bank
  import cwb_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int ADDR_W   = 8,
  parameter int BUS_W    = 32,
  parameter int DIV_W    = 8,
  parameter int STRIDE   = 16,
  parameter int SEL_ADDR = 'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic [NUM_CNT-1:0] cnt_expired,
  output logic               sys_rst_req
);
  localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_ADDR);

  logic               rst_sync_n;
  logic [NUM_CNT-1:0] sel_q, sel_d;
  logic               req_q, req_d;
  logic [NUM_CNT-1:0] act_vec, exp_evt;
  logic [BUS_W-1:0]   ctrl_rd [NUM_CNT];
  logic [BUS_W-1:0]   lo_rd   [NUM_CNT];
  logic [BUS_W-1:0]   hi_rd   [NUM_CNT];

  cwb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(g * STRIDE);
    cwb_counter #(.BUS_W(BUS_W), .DIV_W(DIV_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_ctrl    (bus_we && bus_addr == BASE + ADDR_W'(OFS_CTRL)),
      .wr_lo      (bus_we && bus_addr == BASE + ADDR_W'(OFS_LO)),
      .wr_hi      (bus_we && bus_addr == BASE + ADDR_W'(OFS_HI)),
      .wdata      (bus_wdata),
      .wd_sel     (sel_q[g]),
      .ctrl_rd    (ctrl_rd[g]),
      .lo_rd      (lo_rd[g]),
      .hi_rd      (hi_rd[g]),
      .busy       (act_vec[g]),
      .expire_evt (exp_evt[g]),
      .expired    (cnt_expired[g])
    );
  end

  always_comb begin
    sel_d = sel_q;
    if (bus_we && bus_addr == SEL_A) sel_d = bus_wdata[NUM_CNT-1:0];
    req_d = req_q | (|(exp_evt & sel_q));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= '0;
      req_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      req_q <= req_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == SEL_A) bus_rdata[NUM_CNT-1:0] = sel_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == ADDR_W'(i * STRIDE + OFS_CTRL)) bus_rdata = ctrl_rd[i];
      if (bus_addr == ADDR_W'(i * STRIDE + OFS_LO))   bus_rdata = lo_rd[i];
      if (bus_addr == ADDR_W'(i * STRIDE + OFS_HI))   bus_rdata = hi_rd[i];
    end
  end

  assign sys_rst_req = req_q;
endmodule

// File: rtl/cwb_timer_bank_chk.sv
module cwb_timer_bank_chk #(
  parameter int NUM_CNT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [NUM_CNT-1:0] cnt_expired,
  input logic [NUM_CNT-1:0] act_vec,
  input logic [NUM_CNT-1:0] exp_evt,
  input logic [NUM_CNT-1:0] sel_q,
  input logic               sys_rst_req
);
  // R9: the reset request never drops without a global reset
  a_r9_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    // R9: a marked channel raises the request and leaves its flag alone
    a_r9_wd_request: assert property (@(posedge clk) disable iff (!rst_n)
      exp_evt[i] && sel_q[i] |=> sys_rst_req);
    a_r9_wd_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      exp_evt[i] && sel_q[i] && !cnt_expired[i] |=> !cnt_expired[i]);
    // R8: an unmarked channel sets its flag on expiry
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      exp_evt[i] && !sel_q[i] |=> cnt_expired[i]);
    // R8: the flag only clears through a register write
    a_r8_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnt_expired[i]) |-> $past(bus_we));
    // R7: expiry leaves the channel idle
    a_r7_idle_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      exp_evt[i] |=> !act_vec[i]);
  end
endmodule

bind cwb_timer_bank cwb_timer_bank_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_we      (bus_we),
  .cnt_expired (cnt_expired),
  .act_vec     (act_vec),
  .exp_evt     (exp_evt),
  .sel_q       (sel_q),
  .sys_rst_req (sys_rst_req)
);

// File: tb/sim_cwb_timer_bank.sv
module sim_cwb_timer_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  cnt_expired;
  logic        sys_rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cwb_timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_expired(cnt_expired), .sys_rst_req(sys_rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input logic [7:0] dv, input logic [1:0] md, input logic en);
    return {16'h0, dv, 4'h0, md, 1'b0, en};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R1 sys_rst_req", sys_rst_req, 0);
    chk("R1 cnt_expired", cnt_expired, 0);
    rd(8'h00, d); chk("R1 ctrl0", d, 0);
    rd(8'h38, d); chk("R1 hi3", d, 0);
    rd(8'h40, d); chk("R1 select", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(8'h24, 32'hDEADBEEF);
    wr(8'h28, 32'h12345678);
    wr(8'h20, ctl(8'h37, 2'b10, 1'b0));
    rd(8'h24, d); chk("R3 lo2 readback", d, 32'hDEADBEEF);
    rd(8'h28, d); chk("R3 hi2 readback", d, 32'h12345678);
    rd(8'h20, d); chk("R3 ctrl2 fields", d, 32'h00003708);
    wr(8'h20, 32'h00003702); // busy bit write ignored
    rd(8'h20, d); chk("R3 busy read-only", d, 32'h00003700);
    wr(8'h40, 32'hFFFFFFF5);
    rd(8'h40, d); chk("R2 select width", d, 32'h5);
    wr(8'h40, 32'h0);
    rd(8'h2C, d); chk("R2 unmapped 0x2C", d, 0);
    rd(8'h50, d); chk("R2 unmapped 0x50", d, 0);
    rd(8'h26, d); chk("R2 misaligned 0x26", d, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(8'h04, 32'd3); wr(8'h08, 32'd0);
    wr(8'h00, ctl(8'd4, 2'b00, 1'b1)); // N=3, P=4 -> visible at m=13
    cyc(5);
    rd(8'h00, d); chk("R4 busy while counting", d, 32'h00000403);
    cyc(7); chk("R4 no early expiry", cnt_expired[0], 0);
    cyc(1); chk("R4 expiry at N*P+1", cnt_expired[0], 1);
    rd(8'h00, d); chk("R7 enable kept busy cleared", d, 32'h00000401);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(8'h00, ctl(8'd4, 2'b00, 1'b1));
    cyc(3);
    rd(8'h00, d); chk("R7 re-enable without edge no restart", d, 32'h00000401);
    chk("R8 flag holds", cnt_expired[0], 1);
    wr(8'h00, ctl(8'd4, 2'b00, 1'b0));
    chk("R8 flag holds after disable", cnt_expired[0], 1);
    wr(8'h00, ctl(8'd4, 2'b00, 1'b1));
    chk("R8 flag cleared on enable edge", cnt_expired[0], 0);
    rd(8'h00, d); chk("R7 restart on edge", d, 32'h00000403);
    wr(8'h00, ctl(8'd4, 2'b00, 1'b0));
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(8'h14, 32'd0);
    wr(8'h10, ctl(8'd2, 2'b00, 1'b1));
    chk("R6 not before first edge", cnt_expired[1], 0);
    cyc(1); chk("R6 zero start expires at once", cnt_expired[1], 1);
    rd(8'h10, d); chk("R6 busy cleared", d[1], 0);
  endtask

  task automatic t_div_floor();
    wr(8'h34, 32'd3);
    wr(8'h30, ctl(8'd0, 2'b00, 1'b1)); // divider 0 -> 2, expiry at m=7
    cyc(6); chk("R5 div0 not early", cnt_expired[3], 0);
    cyc(1); chk("R5 div0 acts as 2", cnt_expired[3], 1);
    wr(8'h30, ctl(8'd1, 2'b00, 1'b0));
    wr(8'h30, ctl(8'd1, 2'b00, 1'b1));
    cyc(6); chk("R5 div1 not early", cnt_expired[3], 0);
    cyc(1); chk("R5 div1 acts as 2", cnt_expired[3], 1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(8'h20, ctl(8'd4, 2'b00, 1'b1));
    rd(8'h20, d); chk("R10 idle write accepted", d, 32'h00000403);
    wr(8'h20, ctl(8'd8, 2'b01, 1'b1));
    rd(8'h20, d); chk("R10 fields locked while busy", d, 32'h00000403);
    wr(8'h20, ctl(8'd8, 2'b00, 1'b0));
    rd(8'h20, d); chk("R10 disable write keeps divider", d, 32'h00000400);
    wr(8'h20, ctl(8'd8, 2'b00, 1'b0));
    rd(8'h20, d); chk("R10 idle write takes divider", d, 32'h00000800);
  endtask

  task automatic t_kick();
    logic [31:0] d;
    wr(8'h24, 32'd1000); wr(8'h28, 32'd0);
    wr(8'h20, ctl(8'd2, 2'b00, 1'b1));
    wr(8'h24, 32'd0);
    rd(8'h24, d); chk("R11 busy write stored", d, 0);
    cyc(5);
    chk("R11 running count unchanged", cnt_expired[2], 0);
    rd(8'h20, d); chk("R11 still busy", d, 32'h00000203);
    wr(8'h20, ctl(8'd2, 2'b00, 1'b0));
    wr(8'h24, 32'd3);
    wr(8'h20, ctl(8'd2, 2'b00, 1'b1)); // would expire at m=7
    cyc(3);
    wr(8'h20, ctl(8'd2, 2'b00, 1'b0));
    cyc(12);
    chk("R12 disable stops without expiry", cnt_expired[2], 0);
    rd(8'h20, d); chk("R12 idle after disable", d, 32'h00000200);
    wr(8'h24, 32'd2);
    wr(8'h20, ctl(8'd2, 2'b00, 1'b1)); // N=2,P=2 -> m=5
    cyc(4); chk("R12 kick not early", cnt_expired[2], 0);
    cyc(1); chk("R12 kick reloads new value", cnt_expired[2], 1);
  endtask

  task automatic t_indep();
    wr(8'h34, 32'd5);
    wr(8'h04, 32'd2);
    wr(8'h30, ctl(8'd2, 2'b00, 1'b1)); // E0
    wr(8'h00, ctl(8'd3, 2'b00, 1'b1)); // E1
    cyc(6);  chk("R13 none yet", cnt_expired, 4'b0000);
    cyc(1);  chk("R13 ch0 first", cnt_expired, 4'b0001);
    cyc(2);  chk("R13 ch3 still running", cnt_expired, 4'b0001);
    cyc(1);  chk("R13 ch3 expires", cnt_expired, 4'b1001);
  endtask

  task automatic t_watchdog();
    wr(8'h40, 32'h2);
    wr(8'h14, 32'd1);
    wr(8'h10, ctl(8'd2, 2'b00, 1'b1)); // N=1,P=2 -> m=3
    cyc(2); chk("R9 no early request", sys_rst_req, 0);
    cyc(1); chk("R9 request on expiry", sys_rst_req, 1);
    chk("R9 marked channel flag stays low", cnt_expired[1], 0);
    wr(8'h10, ctl(8'd2, 2'b00, 1'b0));
    cyc(5); chk("R9 request sticky", sys_rst_req, 1);
    do_reset();
    chk("R9 request cleared by reset", sys_rst_req, 0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_map();
    t_basic();
    t_oneshot();
    t_zero();
    t_div_floor();
    t_lock();
    t_kick();
    do_reset();
    t_indep();
    t_watchdog();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule